// File: doc/BRIEF.md
# Reference Impairment Monitor

This block watches a single timing reference, sampled by a much faster master clock, and decides whether that reference can be used. A reference counts as impaired when its edges stop altogether, or when its rate drifts outside a narrow window around the expected nominal rate. A downstream mode controller reads the single impaired flag. That controller drops to free-running operation while the flag is high and returns to locked operation once the flag clears.

The expected nominal rate is chosen from four rates with a two-bit select. The rate is measured by counting reference rising edges between consecutive pulses of an externally supplied window tick. Separately, a silence timer catches a dead reference without waiting for a window to end. The flag rises at once on any failure. To avoid chattering, it falls only after the reference has proven itself over consecutive windows. The block does no phase locking, filtering or reference switching.

Top module: `ref_impair_mon`

## Requirements
- R1: While rst_ni is low, impaired_o is 1 and all counters are zero. impaired_o stays 1 after reset until a passing window clears it.
- R2: ref_i passes through two synchronising flops. Each 0-to-1 transition of the synchronised signal counts as exactly one edge.
- R3: At each cycle with win_tick_i high, the window count is the number of edges since the previous tick, including an edge in the tick cycle itself. The window passes when this count lies in [N-T, N+T], where N is the nominal count and T = max(1, N/TOL_DIV). The edge counter then restarts from zero.
- R4: fsel_i selects the nominal count and the silence limit: 0 for 8 kHz (NOM_S0/LOS_S0), 1 for 1.544 MHz (NOM_S1/LOS_S1), 2 for 2.048 MHz (NOM_S2/LOS_S2), and 3 for 19.44 MHz (NOM_S3/LOS_S3).
- R5: A failing window sets impaired_o to 1 on the clock edge that ends the tick cycle.
- R6: After the silence limit of master cycles (about two reference periods) passes with no edge, impaired_o becomes 1 on the next clock edge, independently of the window count. This holds whether the reference stops low or stops high.
- R7: Outside the post-reset case, impaired_o returns to 0 only at the second of two consecutive passing windows, with no silence condition present at either of them. Any failing window or silence condition restarts this sequence.
- R8: The first passing window after reset clears impaired_o on its own.
- R9: The edge counter saturates at its all-ones value and never wraps. A reference so fast that its count overflows CNT_W bits therefore always fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Timing reference, asynchronous to clk_i |
| fsel_i | input | 2 | Nominal rate select |
| win_tick_i | input | 1 | One-cycle pulse closing each measurement window |
| impaired_o | output | 1 | 1 while the reference is unusable |

## Verification
The hardest case to reach is counter overflow. The counter would have to wrap back into the passing range exactly, so that a counter without saturation would wrongly clear the flag. The bench builds this by reducing CNT_W to 6 bits and driving a reference at five times the nominal rate for select 0, so a wrapping counter would land back on the nominal count. Stimulus changes are also aligned to window ticks. This lets a bench-side model separate the single-pass clear after reset from the two-pass clear required at every later recovery.

// File: rtl/rim_pkg.sv
package rim_pkg;

  localparam int unsigned NUM_RATES = 4;

  typedef enum logic [1:0] {
    RATE_8K    = 2'd0,
    RATE_1M544 = 2'd1,
    RATE_2M048 = 2'd2,
    RATE_19M44 = 2'd3
  } rate_e;

  function automatic int unsigned tol_of(int unsigned nom, int unsigned div);
    int unsigned t;
    t = nom / div;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rim_edge_sync.sv
module rim_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ref_i};
      prev_q <= sync_q[1];
    end
  end

  assign edge_o = sync_q[1] & ~prev_q;

  // an edge is a single-cycle event
  p_edge_isolated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);

endmodule

// File: rtl/rim_rate_sel.sv
module rim_rate_sel import rim_pkg::*; #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LOS_W   = 16,
  parameter int unsigned TOL_DIV = 100,
  parameter int unsigned NOM_S0  = 8,
  parameter int unsigned NOM_S1  = 1544,
  parameter int unsigned NOM_S2  = 2048,
  parameter int unsigned NOM_S3  = 19440,
  parameter int unsigned LOS_S0  = 25000,
  parameter int unsigned LOS_S1  = 130,
  parameter int unsigned LOS_S2  = 98,
  parameter int unsigned LOS_S3  = 11
) (
  input  logic [1:0]       fsel_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [LOS_W-1:0] los_lim_o
);
  localparam int unsigned NOM_TBL [NUM_RATES] = '{NOM_S0, NOM_S1, NOM_S2, NOM_S3};
  localparam int unsigned LOS_TBL [NUM_RATES] = '{LOS_S0, LOS_S1, LOS_S2, LOS_S3};

  logic [CNT_W-1:0] lo_tbl  [NUM_RATES];
  logic [CNT_W-1:0] hi_tbl  [NUM_RATES];
  logic [LOS_W-1:0] lim_tbl [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned TOL = tol_of(NOM_TBL[g], TOL_DIV);
    assign lo_tbl[g]  = CNT_W'(NOM_TBL[g] - TOL);
    assign hi_tbl[g]  = CNT_W'(NOM_TBL[g] + TOL);
    assign lim_tbl[g] = LOS_W'(LOS_TBL[g]);
  end

  assign lo_o      = lo_tbl[fsel_i];
  assign hi_o      = hi_tbl[fsel_i];
  assign los_lim_o = lim_tbl[fsel_i];

endmodule

// File: rtl/rim_win_count.sv
module rim_win_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             eval_o,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] sum;

  assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(edge_i);
  assign sum   = sum_w[CNT_W] ? CNT_MAX : sum_w[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= '0;
    else             cnt_q <= sum;
  end

  assign eval_o = tick_i;
  assign pass_o = tick_i && (sum >= lo_i) && (sum <= hi_i);

  p_cnt_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !tick_i) |=> cnt_q == CNT_MAX);

  p_cnt_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == '0);

endmodule

// File: rtl/rim_los_timer.sv
module rim_los_timer #(
  parameter int unsigned LOS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [LOS_W-1:0] limit_i,
  output logic             los_o
);
  logic [LOS_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (edge_i)            tmr_q <= '0;
    else if (tmr_q < limit_i)   tmr_q <= tmr_q + LOS_W'(1);
  end

  assign los_o = (tmr_q >= limit_i);

  p_edge_clears_los_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && limit_i != '0 && $stable(limit_i)) |=> !los_o);

endmodule

// File: rtl/rim_flag_fsm.sv
module rim_flag_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  input  logic pass_i,
  input  logic los_i,
  output logic impaired_o
);
  logic flag_q;
  logic prev_pass_q;  // preset after reset so the first pass clears

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q      <= 1'b1;
      prev_pass_q <= 1'b1;
    end else if (los_i || (eval_i && !pass_i)) begin
      flag_q      <= 1'b1;
      prev_pass_q <= 1'b0;
    end else if (eval_i) begin
      if (prev_pass_q) flag_q <= 1'b0;
      prev_pass_q <= 1'b1;
    end
  end

  assign impaired_o = flag_q;

  p_los_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> impaired_o);

  p_fail_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !pass_i) |=> impaired_o);

  p_clear_needs_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(impaired_o) |-> $past(eval_i && pass_i && !los_i));

endmodule

// File: rtl/ref_impair_mon.sv
module ref_impair_mon import rim_pkg::*; #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TOL_DIV = 100,
  parameter int unsigned NOM_S0  = 8,
  parameter int unsigned NOM_S1  = 1544,
  parameter int unsigned NOM_S2  = 2048,
  parameter int unsigned NOM_S3  = 19440,
  parameter int unsigned LOS_S0  = 25000,
  parameter int unsigned LOS_S1  = 130,
  parameter int unsigned LOS_S2  = 98,
  parameter int unsigned LOS_S3  = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic [1:0] fsel_i,
  input  logic       win_tick_i,
  output logic       impaired_o
);
  localparam int unsigned LOS_MAX = max4(LOS_S0, LOS_S1, LOS_S2, LOS_S3);
  localparam int unsigned LOS_W   = $clog2(LOS_MAX + 1);

  logic             edge_w;
  logic [CNT_W-1:0] lo_w;
  logic [CNT_W-1:0] hi_w;
  logic [LOS_W-1:0] los_lim_w;
  logic             eval_w;
  logic             pass_w;
  logic             los_w;

  rim_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .edge_o (edge_w)
  );

  rim_rate_sel #(
    .CNT_W(CNT_W), .LOS_W(LOS_W), .TOL_DIV(TOL_DIV),
    .NOM_S0(NOM_S0), .NOM_S1(NOM_S1), .NOM_S2(NOM_S2), .NOM_S3(NOM_S3),
    .LOS_S0(LOS_S0), .LOS_S1(LOS_S1), .LOS_S2(LOS_S2), .LOS_S3(LOS_S3)
  ) u_rate (
    .fsel_i    (fsel_i),
    .lo_o      (lo_w),
    .hi_o      (hi_w),
    .los_lim_o (los_lim_w)
  );

  rim_win_count #(.CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_w),
    .tick_i (win_tick_i),
    .lo_i   (lo_w),
    .hi_i   (hi_w),
    .eval_o (eval_w),
    .pass_o (pass_w)
  );

  rim_los_timer #(.LOS_W(LOS_W)) u_los (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_w),
    .limit_i (los_lim_w),
    .los_o   (los_w)
  );

  rim_flag_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval_w),
    .pass_i     (pass_w),
    .los_i      (los_w),
    .impaired_o (impaired_o)
  );

  p_reset_flag_r1: assert property (@(posedge clk_i)
    !rst_ni |=> impaired_o);

endmodule

// File: tb/ref_impair_mon_bench.sv
module ref_impair_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 400;
  localparam int CNT_W      = 6;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int NOM [4]    = '{16, 20, 25, 50};
  localparam int LIM [4]    = '{50, 40, 32, 16};
  localparam int PER [4]    = '{25, 20, 16, 8};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_s = 1'b0;
  logic [1:0] fsel = 2'd1;
  logic       tick = 1'b0;
  logic       impaired;

  int vectors = 0;
  int fails   = 0;
  int per     = 0;      // 0: reference stopped
  bit stuck_hi = 1'b0;
  int ph      = 0;
  int tcnt    = 0;
  int ticks_seen = 0;
  bit done    = 1'b0;
  string cur_req = "R1";

  // model state
  int  m_s1, m_s2, m_prev, m_cnt, m_tmr;
  bit  m_prev_pass, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_impair_mon #(
    .CNT_W(CNT_W), .TOL_DIV(100),
    .NOM_S0(16), .NOM_S1(20), .NOM_S2(25), .NOM_S3(50),
    .LOS_S0(50), .LOS_S1(40), .LOS_S2(32), .LOS_S3(16)
  ) u_ref_impair_mon (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_i      (ref_s),
    .fsel_i     (fsel),
    .win_tick_i (tick),
    .impaired_o (impaired)
  );

  function automatic int tol_f(int n);
    return (n / 100 == 0) ? 1 : n / 100;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_tmr = 0;
      m_prev_pass = 1'b1; m_flag = 1'b1;
    end else begin
      int e, s, lim, n;
      bit los, ok;
      e   = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
      s   = m_cnt + e;
      if (s > CNT_MAX) s = CNT_MAX;
      n   = NOM[fsel];
      lim = LIM[fsel];
      los = (m_tmr >= lim);
      ok  = (s >= n - tol_f(n)) && (s <= n + tol_f(n));
      if (los || (tick && !ok)) begin
        m_flag = 1'b1; m_prev_pass = 1'b0;
      end else if (tick) begin
        if (m_prev_pass) m_flag = 1'b0;
        m_prev_pass = 1'b1;
      end
      m_cnt = tick ? 0 : s;
      if (e == 1) m_tmr = 0;
      else if (m_tmr < lim) m_tmr = m_tmr + 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(ref_s);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vectors++;
      if (impaired !== m_flag) begin
        fails++;
        $display("FAIL %s cycle-compare: impaired_o=%0b expected=%0b at %0t",
                 cur_req, impaired, m_flag, $time);
      end
      if (tick) ticks_seen++;
      if (rst_n) begin
        tcnt = (tcnt + 1) % WIN;
        tick = (tcnt == WIN - 1);
      end else begin
        tcnt = 0;
        tick = 1'b0;
      end
      if (per > 0) begin
        ref_s = (ph < per / 2);
        ph    = (ph + 1) % per;
      end else begin
        ref_s = stuck_hi;
      end
    end
  endtask

  task automatic win_wait(int k);
    int target;
    target = ticks_seen + k;
    while (ticks_seen < target) cyc(1);
  endtask

  task automatic chk(string req, bit exp);
    vectors++;
    if (impaired !== exp) begin
      fails++;
      $display("FAIL %s: impaired_o=%0b expected=%0b at %0t", req, impaired, exp, $time);
    end
  endtask

  initial begin
    // R1: reset holds flag
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", 1'b1);
    per = 20; ph = 0; fsel = 2'd1;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(5);
    chk("R1", 1'b1);

    // R8: one passing window after reset clears
    cur_req = "R8";
    win_wait(1);
    chk("R8", 1'b0);

    // R5: frequency too high fails at once
    cur_req = "R5";
    per = 17; ph = 0;
    win_wait(1);
    chk("R5", 1'b1);

    // R7: two passes needed to clear
    cur_req = "R7";
    per = 20; ph = 0;
    win_wait(1);
    chk("R7", 1'b1);
    win_wait(1);
    chk("R7", 1'b0);

    // R6: silence low mid-window
    cur_req = "R6";
    cyc(100);
    per = 0; stuck_hi = 1'b0;
    cyc(60);
    chk("R6", 1'b1);
    win_wait(1);
    per = 20; ph = 0;
    win_wait(1);
    chk("R7", 1'b1);
    win_wait(1);
    chk("R7", 1'b0);

    // R6: silence high
    cyc(100);
    per = 0; stuck_hi = 1'b1;
    cyc(60);
    chk("R6", 1'b1);
    win_wait(1);
    per = 20; ph = 0;
    win_wait(2);
    chk("R6", 1'b0);

    // R3: tolerance edges (low side pass, high side fail)
    cur_req = "R3";
    per = 21; ph = 0;
    win_wait(2);
    chk("R3", 1'b0);
    per = 18; ph = 0;
    win_wait(1);
    chk("R3", 1'b1);

    // R4: every select at its nominal rate
    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      fsel = 2'(s); per = PER[s]; ph = 0;
      win_wait(3);
      chk("R4", 1'b0);
    end

    // R4: rate meant for another select fails
    fsel = 2'd2; per = PER[1]; ph = 0;
    win_wait(1);
    chk("R4", 1'b1);

    // R9: overflowing count must fail, not wrap back to nominal
    cur_req = "R9";
    fsel = 2'd0; per = PER[0]; ph = 0;
    win_wait(3);
    chk("R9", 1'b0);
    per = 5; ph = 0;
    win_wait(1);
    chk("R9", 1'b1);
    win_wait(2);
    chk("R9", 1'b1);

    // R2: slow reference edges still counted once each
    cur_req = "R2";
    per = PER[0]; ph = 0;
    win_wait(3);
    chk("R2", 1'b0);

    // R1: reset mid-run reasserts flag
    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 1'b1);
    rst_n = 1'b1;
    cyc(20);
    chk("R1", 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule